// File: doc/BRIEF.md
# Serial DAC Input and Holding-Register Front End

This block is the digital front end of a serial-input digital-to-analog converter. A host frames a word with an active-low chip select and clocks it in, most significant bit first, on rising serial-clock edges. The bits go into a 16-bit shift register. The block does not count them, so the last 16 bits clocked in are what the shift register holds. The output is a holding register whose value is presented as the converter code. That register can be loaded in two ways. The first is at the rising edge of chip select when the active-low load strobe is low. The second is later, from an input latch, whenever the strobe goes low.

A falling edge on the active-low clear input forces the holding register to midscale. While clear stays low, every load request is ignored. A parameter chooses a 16-bit or 12-bit output code. The 12-bit code is the upper 12 bits of the retained word, so shorter data is padded with zeros at the low end.

All serial and control inputs are sampled by a fast system clock that runs well above the serial clock. Edges are found by comparing each input with its value in the previous cycle. A synchronous active-high reset stands for power-up and places midscale in the holding register.

Top module: `sdac_front`

## Requirements
- R1: After reset, dac_code is midscale: the MSB is 1 and all other bits are 0 (0x8000 for 16 bits, 0x800 for 12 bits).
- R2: On each sampled rising edge of sclk while cs_n is low, din enters bit 0 of the shift register and the earlier bits move one place toward the MSB, so the first bit sent ends up as the MSB.
- R3: Rising sclk edges while cs_n is high leave the shift register unchanged.
- R4: When a frame has more than 16 bits, only the last 16 bits clocked in are kept.
- R5: When a frame has fewer than 16 bits, the rest of the word is made up of bits left from the previous contents, shifted up by the number of new bits.
- R6: A rising edge of cs_n with ldac_n low loads the shifted word into the holding register. The new code is visible one system clock after the edge.
- R7: A rising edge of cs_n with ldac_n high leaves dac_code unchanged and keeps the word in an input latch. A later low level on ldac_n copies that latched word to dac_code.
- R8: A falling edge on clr_n sets the holding register to midscale. This takes priority over a low ldac_n in the same cycle.
- R9: While clr_n is low, neither ldac_n nor cs_n rising edges change dac_code, but the input latch still captures new frames.
- R10: With RES_W = 12, dac_code equals bits 15 to 4 of the word the 16-bit variant would show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset standing for power-up |
| cs_n | input | 1 | Active-low chip select that frames a serial word |
| sclk | input | 1 | Serial clock; data taken on its rising edge |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load strobe for the holding register |
| clr_n | input | 1 | Active-low clear, acting on its falling edge |
| dac_code | output | RES_W | Holding-register contents presented to the converter |

## Verification
The bench sends short frames to confirm that leftover bits stay and are shifted up. A design that cleared the register at the start of each frame, or that counted bits, would show zeros or the wrong alignment in place of those bits. It also sends a 20-bit frame, where a design that keeps the first 16 bits instead of the last would show the wrong word.

It toggles sclk while chip select is high and then sends a short frame, so any stray shift would appear as extra ones in the code. It loads a word with the strobe high and checks that the output does not change until the strobe is pulsed, which separates the latched path from the direct path.

It holds clear low while sending strobe pulses and frames, and drives clear and the strobe low in the same cycle. A design that lets the strobe override clear would leave midscale, and a design that treats clear as level-sensitive across its release would lose the word kept in the latch.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    // Serial word length accepted on the wire; the retained window.
    localparam int FRAME_W = 16;

    typedef logic [FRAME_W-1:0] frame_t;

    // Source chosen for the holding register in one cycle.
    typedef enum logic [1:0] {
        UPD_KEEP   = 2'd0,
        UPD_MID    = 2'd1,
        UPD_DIRECT = 2'd2,
        UPD_HELD   = 2'd3
    } upd_e;

    // Decoded control events for one sampling cycle.
    typedef struct packed {
        logic cs_rise;
        logic clr_fall;
        logic clr_low;
        logic ldac_low;
    } ctl_t;

    function automatic upd_e pick_update(ctl_t c);
        if (c.clr_fall)      return UPD_MID;
        else if (c.clr_low)  return UPD_KEEP;
        else if (c.ldac_low) return c.cs_rise ? UPD_DIRECT : UPD_HELD;
        else                 return UPD_KEEP;
    endfunction

endpackage

// File: rtl/sdac_edge.sv
module sdac_edge #(
    parameter logic IDLE   = 1'b0,
    parameter bit   RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic evt
);

    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= IDLE;
        else     sig_q <= sig;
    end

    generate
        if (RISING) begin : g_rise
            assign evt = sig & ~sig_q;
        end else begin : g_fall
            assign evt = ~sig & sig_q;
        end
    endgenerate

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
    import sdac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   shift_en,
    input  logic   din,
    output frame_t sreg
);

    // No reset: contents are undefined at power-up.
    always_ff @(posedge clk) begin
        if (shift_en) sreg <= {sreg[FRAME_W-2:0], din};
    end

    // R2: new bit lands in the LSB
    assert_lsb_in_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sreg[0] == $past(din));

    // R2: older bits move toward the MSB
    assert_move_up_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sreg[FRAME_W-1:1] == $past(sreg[FRAME_W-2:0]));

endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
    import sdac_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RES_W-1:0] word,
    input  ctl_t             ctl,
    output logic [RES_W-1:0] dac_q
);

    localparam logic [RES_W-1:0] MID = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] hold_q;
    upd_e             sel;

    always_ff @(posedge clk) begin
        if (rst)              hold_q <= MID;
        else if (ctl.cs_rise) hold_q <= word;
    end

    always_comb sel = pick_update(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q <= MID;
        end else begin
            case (sel)
                UPD_MID:    dac_q <= MID;
                UPD_DIRECT: dac_q <= word;
                UPD_HELD:   dac_q <= hold_q;
                default:    dac_q <= dac_q;
            endcase
        end
    end

    // R8: clear edge yields midscale
    assert_clear_mid_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.clr_fall |=> dac_q == MID);

    // R9: clear held low freezes the output
    assert_clr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr_low && !ctl.clr_fall) |=> $stable(dac_q));

    // R7: strobe high means no change
    assert_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctl.ldac_low && !ctl.clr_fall) |=> $stable(dac_q));

    // R6: direct load at chip-select rise
    assert_direct_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.cs_rise && ctl.ldac_low && !ctl.clr_low && !ctl.clr_fall)
            |=> dac_q == $past(word));

    // R7: frame captured in the input latch
    assert_latch_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.cs_rise |=> hold_q == $past(word));

endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             ldac_n,
    input  logic             clr_n,
    output logic [RES_W-1:0] dac_code
);

    localparam int DROP_W = FRAME_W - RES_W;

    logic       sclk_rise;
    logic       cs_rise;
    logic       clr_fall;
    frame_t     shreg;
    ctl_t       ctl;
    logic [RES_W-1:0] word_res;

    sdac_edge #(.IDLE(1'b0), .RISING(1'b1)) u_sclk_edge (
        .clk(clk), .rst(rst), .sig(sclk), .evt(sclk_rise));

    sdac_edge #(.IDLE(1'b1), .RISING(1'b1)) u_cs_edge (
        .clk(clk), .rst(rst), .sig(cs_n), .evt(cs_rise));

    sdac_edge #(.IDLE(1'b1), .RISING(1'b0)) u_clr_edge (
        .clk(clk), .rst(rst), .sig(clr_n), .evt(clr_fall));

    sdac_shift u_shift (
        .clk(clk), .rst(rst), .shift_en(sclk_rise & ~cs_n),
        .din(din), .sreg(shreg));

    generate
        if (DROP_W == 0) begin : g_full
            assign word_res = shreg;
        end else begin : g_reduced
            assign word_res = shreg[FRAME_W-1 -: RES_W];
        end
    endgenerate

    always_comb begin
        ctl.cs_rise  = cs_rise;
        ctl.clr_fall = clr_fall;
        ctl.clr_low  = ~clr_n;
        ctl.ldac_low = ~ldac_n;
    end

    sdac_latch #(.RES_W(RES_W)) u_latch (
        .clk(clk), .rst(rst), .word(word_res), .ctl(ctl), .dac_q(dac_code));

    // R3: deselected shifter is frozen
    assert_cs_high_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(shreg));

    initial assert (RES_W == 12 || RES_W == 16);

endmodule

// File: tb/sim_sdac_front.sv
`timescale 1ns/1ps
module sim_sdac_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic [15:0] code16;
    logic [11:0] code12;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sdac_front #(.RES_W(16)) u0 (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .din(din), .ldac_n(ldac_n), .clr_n(clr_n), .dac_code(code16));
    sdac_front #(.RES_W(12)) u1 (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .din(din), .ldac_n(ldac_n), .clr_n(clr_n), .dac_code(code12));

    // stimulus table: word, bit count, strobe low at chip-select rise, expected code
    localparam logic [15:0] VWORD [8] = '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h1234,
                                          16'h00AB, 16'h8000, 16'h7FFE, 16'h0F0F};
    localparam int          VLEN  [8] = '{16, 16, 16, 16, 8, 16, 16, 4};
    localparam bit          VLDL  [8] = '{1, 1, 1, 1, 1, 0, 1, 1};
    localparam logic [15:0] VEXP  [8] = '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h1234,
                                          16'h34AB, 16'h34AB, 16'h7FFE, 16'hFFEF};

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] exp16);
        total += 2;
        if (code16 !== exp16) begin
            bad++;
            $display("FAIL %s 16-bit: got %h want %h", tag, code16, exp16);
        end
        if (code12 !== exp16[15:4]) begin
            bad++;
            $display("FAIL %s/R10 12-bit: got %h want %h", tag, code12, exp16[15:4]);
        end
    endtask

    // frame of n bits taken from the low end of w, MSB first
    task automatic send(input logic [31:0] w, input int n, input bit ldac_low_at_end);
        tick();
        cs_n = 1'b0;
        for (int b = n - 1; b >= 0; b--) begin
            din = w[b];
            tick();
            sclk = 1'b1;
            tick();
            sclk = 1'b0;
        end
        tick();
        cs_n = 1'b1;
        ldac_n = ldac_low_at_end ? 1'b0 : 1'b1;
        tick();
        ldac_n = 1'b1;
    endtask

    task automatic strobe();
        ldac_n = 1'b0;
        tick();
        ldac_n = 1'b1;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset midscale", 16'h8000);

        // table walk: R2 R5 R6 R7
        for (int i = 0; i < 8; i++) begin
            send({16'h0, VWORD[i]}, VLEN[i], VLDL[i]);
            chk($sformatf("R2/R5/R6/R7 vector %0d", i), VEXP[i]);
        end

        // R4: 20-bit frame keeps the last 16
        send(32'h000F1357, 20, 1'b1);
        chk("R4 long frame", 16'h1357);

        // R7: strobe high, word latched but not shown
        send(32'h2468, 16, 1'b0);
        chk("R7 held off", 16'h1357);

        // R3: sclk edges while deselected
        din = 1'b1;
        for (int k = 0; k < 5; k++) begin
            tick(); sclk = 1'b1; tick(); sclk = 1'b0;
        end
        din = 1'b0;
        tick();
        chk("R3 no shift while deselected", 16'h1357);
        strobe();
        chk("R7 latched word via strobe", 16'h2468);
        send(32'h0, 4, 1'b1);
        chk("R3 shift register untouched", 16'h4680);

        // R8: clear edge
        clr_n = 1'b0;
        tick();
        chk("R8 clear to midscale", 16'h8000);

        // R9: pulses ignored while clear low
        strobe();
        tick();
        chk("R9 strobe ignored", 16'h8000);
        send(32'h4321, 16, 1'b1);
        chk("R9 frame load ignored", 16'h8000);
        clr_n = 1'b1;
        tick(); tick();
        chk("R9 release keeps midscale", 16'h8000);
        strobe();
        chk("R9 latch kept during clear", 16'h4321);

        // R8: clear beats a simultaneous low strobe
        ldac_n = 1'b0;
        clr_n = 1'b0;
        tick();
        chk("R8 clear over strobe", 16'h8000);
        tick();
        chk("R9 strobe low under clear", 16'h8000);
        ldac_n = 1'b1;
        clr_n = 1'b1;
        tick();

        // R1: reset in mid-run
        send(32'h5A5A, 16, 1'b1);
        chk("R6 load before reset", 16'h5A5A);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        chk("R1 reset again", 16'h8000);
        strobe();
        chk("R1 latch reset to midscale", 16'h8000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout want completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule